// File: doc/BRIEF.md
# Parallel NOR Flash Erase Engine

This block is the erase controller of a parallel NOR flash model, together with the logic that answers reads while an erase is running. A command decoder upstream turns bus writes into single-cycle requests: a sector erase with an address, a whole-array erase, and a suspend. The engine keeps a bitmap of pending sectors. After a sector request it opens a collection window. Every further sector request inside that window sets another bit and restarts the window. When the window closes, the engine runs a timed erase of every marked sector. The words of those sectors are then all ones.

While the engine is working, a read returns a status word instead of array data. Two bits toggle on every read, so software can poll for completion. A third bit tells whether the collection window has closed. A suspended erase leaves the sectors that are not being erased readable as normal data. A sector request made while suspended resumes the erase. The array is a small register file whose words reset to `INIT_BASE + address`. Sector boundaries come from four regions. Each region has its own sector count and a power-of-two sector size in words.

Top module: `flash_erase_engine`

## Requirements
- R1: After reset `busy` is 0, and a read returns `INIT_BASE + address` at every word. A suspend request while idle changes neither.
- R2: A sector request erases only the sector that holds `req_addr`. The sector is found from the four region counts and sizes, with region 0 at address 0. Every word of that sector then reads 16'hFFFF, and every other word keeps its contents.
- R3: A sector request during the collection window adds its sector and restarts the window. Status bit 3 reads 0 while the window is open and 1 once erasing has begun, exactly `WIN_CYC` cycles after the last accepted request.
- R4: `busy` rises with the first accepted request. Without a suspend, it falls exactly `WIN_CYC + ERASE_CYC` cycles after the last sector request.
- R5: While the engine is busy and not suspended, a read returns a status word. Bit 7 of that word is 0, and every bit other than 7, 6, 3 and 2 is 0.
- R6: While the engine is busy and not suspended, status bits 6 and 2 both invert on each successive read, at any address.
- R7: A chip request in idle marks every sector and skips the window. The first status read shows bit 3 as 1, `busy` falls exactly `ERASE_CYC` cycles later, and every word then reads 16'hFFFF.
- R8: A suspend request in the window or in the erase phase freezes the timer and keeps `busy` high. A read in a pending sector then shows bit 6 steady and bit 2 inverting. A read in any other sector returns stable array data.
- R9: A sector request while suspended resumes the erase and does not add its own address to the pending set. Bit 3 then reads 1, and bits 6 and 2 invert at all addresses. An erase suspended in the window gets a full `ERASE_CYC`. One suspended in the erase phase completes after its remaining cycles.
- R10: Sector and chip requests in the erase phase are ignored, and so is a chip request in the window.
- R11: Completion clears the pending set and drops `busy`. Two consecutive reads then return identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_req | input | 1 | Sector-erase request pulse; acts as resume while suspended |
| chip_req | input | 1 | Whole-array erase request pulse |
| susp_req | input | 1 | Erase-suspend request pulse |
| req_addr | input | AW | Word address of a sector request |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | AW | Word address of a read |
| rd_data | output | DW | Registered read result: array data or status word |
| busy | output | 1 | High while an erase is pending, running or suspended |

## Verification
Read data is registered. A strobe presented before a clock edge is answered after that edge, and it sees the engine state from before the edge. A request accepted at edge E moves the window-to-erase boundary to edge E+`WIN_CYC`. The bench therefore reads at E+`WIN_CYC` and expects bit 3 at 0, then reads at E+`WIN_CYC`+1 and expects 1. `busy` is checked one cycle before and exactly at E+`WIN_CYC`+`ERASE_CYC`. For a resume at edge R after a suspend in the erase phase, the completion edge is R+`ERASE_CYC`−c, where c is the count of erase cycles already spent. The bench counts every edge from a free-running cycle counter and samples only at falling edges. This keeps each check on its due cycle.

// File: rtl/flash_erase_engine.sv
module flash_erase_engine #(
  parameter int DW = 16,
  parameter int CNT0 = 3,
  parameter int CNT1 = 1,
  parameter int CNT2 = 2,
  parameter int CNT3 = 1,
  parameter int SZL0 = 3,
  parameter int SZL1 = 2,
  parameter int SZL2 = 0,
  parameter int SZL3 = 1,
  parameter int WIN_CYC = 20,
  parameter int ERASE_CYC = 40,
  parameter logic [DW-1:0] INIT_BASE = 16'h3C00,
  localparam int TOTAL = (CNT0 << SZL0) + (CNT1 << SZL1) + (CNT2 << SZL2) + (CNT3 << SZL3),
  localparam int AW = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_req,
  input  logic          chip_req,
  input  logic          susp_req,
  input  logic [AW-1:0] req_addr,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int NSEC = CNT0 + CNT1 + CNT2 + CNT3;
  localparam int SW = $clog2(NSEC + 1);
  localparam int MAXC = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam int CNT [4] = '{CNT0, CNT1, CNT2, CNT3};
  localparam int SZL [4] = '{SZL0, SZL1, SZL2, SZL3};

  typedef enum logic [1:0] {S_IDLE, S_WIN, S_ERS, S_SUSP} st_t;

  function automatic int sec_of(int a);
    int base = 0;
    int sb = 0;
    for (int r = 0; r < 4; r++) begin
      if (a >= base && a < base + (CNT[r] << SZL[r]))
        return sb + ((a - base) >> SZL[r]);
      base = base + (CNT[r] << SZL[r]);
      sb = sb + CNT[r];
    end
    return NSEC;
  endfunction

  function automatic logic [DW-1:0] stat(logic d6, logic d3, logic d2);
    logic [DW-1:0] v = '0;
    v[6] = d6;
    v[3] = d3;
    v[2] = d2;
    return v;
  endfunction

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [NSEC-1:0]  pend;
  logic             from_win;
  logic             tog6, tog2;
  logic [DW-1:0]    mem [TOTAL];

  logic [SW-1:0]    req_sec, rd_sec;
  logic             req_ok, rd_hit, finish;
  logic [NSEC:0]    pend_x;
  logic [NSEC-1:0]  req_bit;
  logic [DW-1:0]    mem_rd;

  assign req_sec = SW'(sec_of(int'(req_addr)));
  assign rd_sec  = SW'(sec_of(int'(rd_addr)));
  assign req_ok  = int'(req_sec) < NSEC;
  assign pend_x  = {1'b0, pend};
  assign rd_hit  = pend_x[rd_sec];
  assign req_bit = req_ok ? (NSEC'(1) << req_sec) : '0;
  assign finish  = (state == S_ERS) && (cnt == CW'(ERASE_CYC - 1));
  assign mem_rd  = mem[rd_addr];
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      pend <= '0;
      from_win <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (chip_req) begin
            pend <= '1;
            state <= S_ERS;
            cnt <= '0;
          end else if (sec_req && req_ok) begin
            pend <= req_bit;
            state <= S_WIN;
            cnt <= '0;
          end
        end
        S_WIN: begin
          if (susp_req) begin
            state <= S_SUSP;
            from_win <= 1'b1;
          end else if (sec_req && req_ok) begin
            pend <= pend | req_bit;
            cnt <= '0;
          end else if (cnt == CW'(WIN_CYC - 1)) begin
            state <= S_ERS;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_ERS: begin
          if (susp_req) begin
            state <= S_SUSP;
            from_win <= 1'b0;
          end else if (finish) begin
            pend <= '0;
            state <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          if (sec_req) begin
            state <= S_ERS;
            if (from_win) cnt <= '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < TOTAL; w++) mem[w] <= DW'(INIT_BASE + DW'(w));
    end else if (finish) begin
      for (int w = 0; w < TOTAL; w++)
        if (pend_x[SW'(sec_of(w))]) mem[w] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (rd_stb) begin
      case (state)
        S_IDLE: rd_data <= mem_rd;
        S_WIN, S_ERS: begin
          rd_data <= stat(tog6, state == S_ERS, tog2);
          tog6 <= ~tog6;
          tog2 <= ~tog2;
        end
        default: begin
          if (rd_hit) begin
            rd_data <= stat(tog6, 1'b0, tog2);
            tog2 <= ~tog2;
          end else begin
            rd_data <= mem_rd;
          end
        end
      endcase
    end
  end

  a_r4_busy_has_work: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pend != '0));
  a_r11_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pend == '0));
  a_r3_window_dq3_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && state == S_WIN) |=> !rd_data[3]);
  a_r5_dq7_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (state == S_WIN || state == S_ERS)) |=> !rd_data[7]);
  a_r8_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SUSP && !sec_req) |=> $stable(cnt));
  a_r8_dq6_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SUSP) |=> $stable(tog6));
  a_r7_chip_marks_all: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && chip_req) |=> (state == S_ERS && (&pend)));
endmodule

// File: tb/sim_flash_erase_engine.sv
`timescale 1ns/1ps
module sim_flash_erase_engine;
  localparam int C0 = 3, C1 = 1, C2 = 2, C3 = 1;
  localparam int L0 = 3, L1 = 2, L2 = 0, L3 = 1;
  localparam int WIN = 20, ERS = 40;
  localparam logic [15:0] IB = 16'h3C00;
  localparam int NS = 7, TOT = 32, AW = 5;
  localparam int RC [4] = '{C0, C1, C2, C3};
  localparam int RL [4] = '{L0, L1, L2, L3};

  logic clk = 0, rst_n = 0, sec_req = 0, chip_req = 0, susp_req = 0, rd_stb = 0;
  logic [AW-1:0] req_addr = '0, rd_addr = '0;
  logic [15:0] rd_data;
  logic busy;
  int cyc = 0, n_chk = 0, n_fail = 0;
  logic [15:0] ex [TOT];

  flash_erase_engine #(.DW(16), .CNT0(C0), .CNT1(C1), .CNT2(C2), .CNT3(C3),
    .SZL0(L0), .SZL1(L1), .SZL2(L2), .SZL3(L3), .WIN_CYC(WIN), .ERASE_CYC(ERS),
    .INIT_BASE(IB)) u0 (.clk(clk), .rst_n(rst_n), .sec_req(sec_req), .chip_req(chip_req),
    .susp_req(susp_req), .req_addr(req_addr), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int first_of(int s);
    int base = 0;
    int sb = 0;
    for (int r = 0; r < 4; r++) begin
      if (s < sb + RC[r]) return base + ((s - sb) << RL[r]);
      base = base + (RC[r] << RL[r]);
      sb = sb + RC[r];
    end
    return TOT;
  endfunction

  function automatic int sec_of(int a);
    for (int s = 0; s < NS; s++)
      if (a >= first_of(s) && a < first_of(s + 1)) return s;
    return NS;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; sec_req = 0; chip_req = 0; susp_req = 0; rd_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int w = 0; w < TOT; w++) ex[w] = IB + 16'(w);
  endtask

  task automatic p_sec(int a, output int t);
    sec_req = 1; req_addr = AW'(a);
    @(negedge clk);
    sec_req = 0; t = cyc;
  endtask

  task automatic p_chip(output int t);
    chip_req = 1;
    @(negedge clk);
    chip_req = 0; t = cyc;
  endtask

  task automatic p_susp(output int t);
    susp_req = 1;
    @(negedge clk);
    susp_req = 0; t = cyc;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    rd_stb = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_stb = 0; d = rd_data;
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_idle(string req);
    int k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
    chk(req, 16'(busy), 16'h0);
  endtask

  task automatic erase_sec(int s);
    for (int w = first_of(s); w < first_of(s + 1); w++) ex[w] = 16'hFFFF;
  endtask

  task automatic check_array(string req);
    logic [15:0] d;
    for (int w = 0; w < TOT; w++) begin rd(w, d); chk(req, d, ex[w]); end
  endtask

  task automatic pair_toggle(string req, int a, bit t6, bit t2);
    logic [15:0] d0, d1;
    rd(a, d0); rd(a, d1);
    chk(req, 16'(d0[6] ^ d1[6]), 16'(t6));
    chk(req, 16'(d0[2] ^ d1[2]), 16'(t2));
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0, t1, ts, tr, c;
    logic [15:0] d, d2;
    do_reset();
    // R1 reset state and idle suspend ignored
    chk("R1 busy", 16'(busy), 16'h0);
    p_susp(t0);
    chk("R1 susp idle busy", 16'(busy), 16'h0);
    check_array("R1 reset array");

    // R2 / R11: each sector alone, addressed by its last word
    for (int s = 0; s < NS; s++) begin
      do_reset();
      p_sec(first_of(s + 1) - 1, t0);
      chk("R4 busy rises", 16'(busy), 16'h1);
      if (s == 0) begin
        rd(5, d); chk("R3 dq3 in window", 16'(d[3]), 16'h0);
        wait_until(t0 + WIN - 1);
        rd(5, d); chk("R3 dq3 last window cycle", 16'(d[3]), 16'h0);
        rd(5, d); chk("R3 dq3 erase start", 16'(d[3]), 16'h1);
        wait_until(t0 + WIN + ERS - 1);
        chk("R4 busy before end", 16'(busy), 16'h1);
        @(negedge clk);
        chk("R4 busy at end", 16'(busy), 16'h0);
      end
      wait_idle("R2 completes");
      erase_sec(s);
      check_array("R2 sector erase");
      rd(first_of(s), d); rd(first_of(s), d2);
      chk("R11 stable reads", d2, d);
    end

    // R3 / R5 / R6 / R10: queued sectors and ignored requests
    do_reset();
    p_sec(0, t0);
    wait_until(t0 + 5);
    p_sec(29, t1);
    rd(16, d);
    chk("R5 dq7 low", 16'(d[7]), 16'h0);
    chk("R5 other bits zero", d & 16'hFF33, 16'h0);
    chk("R3 dq3 window", 16'(d[3]), 16'h0);
    pair_toggle("R6 erased sector", 29, 1, 1);
    pair_toggle("R6 other sector", 16, 1, 1);
    p_chip(c);
    wait_until(t1 + WIN + 5);
    p_sec(24, c);
    p_chip(c);
    rd(24, d);
    chk("R3 dq3 erase", 16'(d[3]), 16'h1);
    chk("R5 other bits zero erase", d & 16'hFF33, 16'h0);
    pair_toggle("R6 during erase", 3, 1, 1);
    wait_until(t1 + WIN + ERS - 1);
    chk("R3 restart busy before end", 16'(busy), 16'h1);
    @(negedge clk);
    chk("R3 restart busy at end", 16'(busy), 16'h0);
    erase_sec(0); erase_sec(5);
    check_array("R10 only queued sectors");

    // R7 chip erase
    do_reset();
    p_chip(t0);
    rd(7, d);
    chk("R7 dq3 immediate", 16'(d[3]), 16'h1);
    chk("R7 dq7 low", 16'(d[7]), 16'h0);
    wait_until(t0 + ERS - 1);
    chk("R7 busy before end", 16'(busy), 16'h1);
    @(negedge clk);
    chk("R7 busy at end", 16'(busy), 16'h0);
    for (int s = 0; s < NS; s++) erase_sec(s);
    check_array("R7 all ones");
    rd(31, d); rd(31, d2);
    chk("R11 stable after chip", d2, d);

    // R8 / R9: suspend inside the window
    do_reset();
    p_sec(24, t0);
    rd(24, d); chk("R3 dq3 window", 16'(d[3]), 16'h0);
    p_susp(ts);
    wait_until(t0 + WIN + ERS + 5);
    chk("R8 busy held", 16'(busy), 16'h1);
    pair_toggle("R8 pending sector", 24, 0, 1);
    rd(0, d); chk("R8 other sector data", d, ex[0]);
    rd(0, d); chk("R8 other sector stable", d, ex[0]);
    p_sec(28, tr);
    rd(24, d); chk("R9 dq3 after resume", 16'(d[3]), 16'h1);
    pair_toggle("R9 pending sector", 24, 1, 1);
    pair_toggle("R9 other sector", 0, 1, 1);
    wait_until(tr + ERS - 1);
    chk("R9 busy before end", 16'(busy), 16'h1);
    @(negedge clk);
    chk("R9 busy at end", 16'(busy), 16'h0);
    erase_sec(3);
    check_array("R9 resume address not added");

    // R8 / R9: suspend in the erase phase
    do_reset();
    p_sec(16, t0);
    wait_until(t0 + WIN + 10);
    p_susp(ts);
    c = ts - t0 - WIN - 1;
    wait_until(ts + 60);
    chk("R8 busy frozen", 16'(busy), 16'h1);
    pair_toggle("R8 pending sector erase phase", 17, 0, 1);
    rd(25, d); chk("R8 other sector data", d, ex[25]);
    p_sec(0, tr);
    rd(17, d); chk("R9 dq3 after resume", 16'(d[3]), 16'h1);
    wait_until(tr + ERS - c - 1);
    chk("R9 remaining busy", 16'(busy), 16'h1);
    @(negedge clk);
    chk("R9 remaining done", 16'(busy), 16'h0);
    erase_sec(2);
    check_array("R9 suspended erase result");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule